// File: doc/BRIEF.md
# Prescaled Event Timer (8-bit)

This block is the timer/counter of a small microcontroller core. An 8-bit counter advances on one of two event sources. The first is the one-cycle instruction strobe. The second is an edge on an external pin, and a control bit picks whether the rising or the falling edge counts. A power-of-two prescaler sits between the selected source and the counter. A control bit can route around the prescaler, so that every event reaches the counter.

The prescaler's running count is not visible to software. Four things clear it:

- a write to the counter,
- a write to the control register,
- the asynchronous power-on/external reset,
- the synchronous watchdog-timeout reset.

When the counter wraps from 0xFF to 0x00 it sets a sticky overflow flag. An interrupt controller outside this block picks the flag up. Software clears the flag by writing zero to it.

The block has no streaming data path. Every pin is a plain control or status signal, and none of them uses a valid/ready handshake. Because there is no back-pressure, a bus write takes effect on the clock edge where it is presented, and the read ports always show the current register values.

Top module: `evt_timer8`

## Requirements
- R1: While `rst_n` is low, and on the clock edge where `wdt_rst` is high, the counter, the overflow flag, the control register and the prescaler count are all set to zero.
- R2: The control register has a source-select bit at position 5. When it is 0, the counter advances on `cyc_en` strobes and pin edges are ignored. When it is 1, the counter advances on pin edges and `cyc_en` is ignored.
- R3: The pin passes through a two-stage synchronizer before edge detection. The edge-select bit at position 4 picks the edge: 0 counts rising edges and 1 counts falling edges. A pin change first sampled at clock edge k changes the counter at edge k+2 when the prescaler is bypassed.
- R4: Control bits [2:0] hold the ratio field n. When control bit 3 is 0, the counter advances once every 2^(n+1) selected events. When control bit 3 is 1, the counter advances on every event.
- R5: A counter write loads `cnt_wdata`, and `cnt_rdata` always shows the current counter value.
- R6: A counter write clears the prescaler count, so a full 2^(n+1) further events are needed for the next advance.
- R7: A control write clears the prescaler count. An event in the same cycle as a control write is not counted.
- R8: An advance from 0xFF gives 0x00 and sets `ovf_flag`.
- R9: `ovf_flag` stays set until a flag write with data 0. A flag write with data 1 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R10: A counter write in the same cycle as an advance loads the written value, and the advance is lost.
- R11: `ctrl_rdata` returns the last value written to the control register, all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on/external reset |
| wdt_rst | input | 1 | Synchronous watchdog-timeout reset, active high |
| ext_pin | input | 1 | Asynchronous external count input |
| cyc_en | input | 1 | Instruction-cycle strobe, one clock wide |
| cnt_wr | input | 1 | Counter write enable |
| cnt_wdata | input | 8 | Counter write data |
| cnt_rdata | output | 8 | Current counter value |
| ctrl_wr | input | 1 | Control register write enable |
| ctrl_wdata | input | 8 | Control write data: [5] source, [4] edge, [3] bypass, [2:0] ratio |
| ctrl_rdata | output | 8 | Control register value |
| flag_wr | input | 1 | Overflow flag write enable |
| flag_wdata | input | 1 | Overflow flag write data (0 clears) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The counting path is driven in four ways:

- Strobe trains with random gaps at every ratio, which separate a correct divide-by-2^(n+1) from an off-by-one in the ratio limit.
- Pin toggle trains under both edge polarities, which separate rising from falling detection and show whether events leak from the source that is not selected.
- Directed sequences that leave the prescaler part-way through a period and then write the counter or the control register. These show whether the hidden prescaler count was really cleared.
- Collisions in a single cycle: a write against an advance, and a flag clear against a wrap. These pin down the stated priorities.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int CTRL_W  = 8;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic [1:0]         spare;
    logic               src_ext;
    logic               fall_edge;
    logic               bypass;
    logic [RATIO_W-1:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/evtmr_edge.sv
module evtmr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh <= '0;
    else if (wdt_rst) sh <= '0;
    else              sh <= {sh[SH_W-2:0], pin};
  end

  assign rise   =  sh[SH_W-2] & ~sh[SH_W-1];
  assign fall   = ~sh[SH_W-2] &  sh[SH_W-1];
  assign edge_o = fall_sel ? fall : rise;

  // R3: an edge of either kind lasts one cycle
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    rise |=> !rise);
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    fall |=> !fall);
endmodule

// File: rtl/evtmr_presc.sv
module evtmr_presc #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               tick,
  input  logic               clr,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               inc
);
  localparam int PRE_W = 2 ** RATIO_W;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] lim;
  logic             at_lim;

  for (genvar i = 0; i < PRE_W; i++) begin : g_lim
    assign lim[i] = (RATIO_W'(i) <= ratio);
  end

  assign at_lim = (pre_cnt == lim);
  assign inc    = tick & ~clr & (bypass | at_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_cnt <= '0;
    else if (wdt_rst || clr)    pre_cnt <= '0;
    else if (tick && !bypass)   pre_cnt <= at_lim ? '0 : pre_cnt + PRE_W'(1);
  end

  // R6/R7: a clear request leaves the prescaler at zero
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    clr |=> pre_cnt == '0);
  // R4: without an event the prescaler holds; in bypass it never moves
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    (!clr && (!tick || bypass)) |=> $stable(pre_cnt));
  // R4: the count stays inside the selected period
  always_ff @(posedge clk) begin
    if (rst_n && !wdt_rst) p_range_r4: assert (pre_cnt <= lim);
  end
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wdt_rst,
  input  logic          inc,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  output logic [CW-1:0] cnt,
  output logic          flag
);
  logic wrap;
  assign wrap = inc & ~wr & (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wdt_rst) cnt <= '0;
    else if (wr)      cnt <= wdata;
    else if (inc)     cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flag <= 1'b0;
    else if (wdt_rst)                flag <= 1'b0;
    else if (wrap)                   flag <= 1'b1;
    else if (flag_wr && !flag_wdata) flag <= 1'b0;
  end

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    wr |=> cnt == $past(wdata));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    (inc && !wr) |=> cnt == $past(cnt) + CW'(1));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    (!inc && !wr) |=> $stable(cnt));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    (inc && !wr && cnt == '1) |=> (cnt == '0 && flag));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    (flag && !(flag_wr && !flag_wdata)) |=> flag);
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evtmr_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst,
  input  logic              ext_pin,
  input  logic              cyc_en,
  input  logic              cnt_wr,
  input  logic [CW-1:0]     cnt_wdata,
  output logic [CW-1:0]     cnt_rdata,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic              ovf_flag
);
  ctrl_t ctrl_q;
  logic  pin_evt, tick, presc_clr, inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wdt_rst) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(ctrl_wdata);
  end
  assign ctrl_rdata = CTRL_W'(ctrl_q);

  evtmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
    .pin(ext_pin), .fall_sel(ctrl_q.fall_edge), .edge_o(pin_evt)
  );

  assign tick      = ctrl_q.src_ext ? pin_evt : cyc_en;
  assign presc_clr = cnt_wr | ctrl_wr;

  evtmr_presc #(.RATIO_W(RATIO_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
    .tick(tick), .clr(presc_clr), .bypass(ctrl_q.bypass),
    .ratio(ctrl_q.ratio), .inc(inc)
  );

  evtmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
    .inc(inc), .wr(cnt_wr), .wdata(cnt_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .cnt(cnt_rdata), .flag(ovf_flag)
  );

  p_ctrl_rb_r11: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    ctrl_wr |=> ctrl_rdata == $past(ctrl_wdata));
  p_src_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n || wdt_rst)
    (!ctrl_q.src_ext && !cyc_en && !cnt_wr) |=> $stable(cnt_rdata));
  p_wdt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (cnt_rdata == '0 && !ovf_flag && ctrl_rdata == '0));
endmodule

// File: tb/evt_timer8_tb.sv
`timescale 1ns/1ps
module evt_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, wdt_rst = 1'b0, ext_pin = 1'b0, cyc_en = 1'b0;
  logic       cnt_wr = 1'b0, ctrl_wr = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [7:0] cnt_wdata = '0, ctrl_wdata = '0;
  logic [7:0] cnt_rdata, ctrl_rdata;
  logic       ovf_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .ext_pin(ext_pin), .cyc_en(cyc_en),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ovf_flag(ovf_flag)
  );

  function automatic int div_for(logic [7:0] c);
    return c[3] ? 1 : (2 << int'(c[2:0]));
  endfunction

  function automatic int total_after(logic [7:0] start, int ev, logic [7:0] c);
    return int'(start) + ev / div_for(c);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; cyc(1); ctrl_wr = 1'b0;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; cyc(1); cnt_wr = 1'b0;
  endtask

  task automatic wr_flag(logic v);
    flag_wr = 1'b1; flag_wdata = v; cyc(1); flag_wr = 1'b0;
  endtask

  task automatic strobes(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc_en = 1'b1; cyc(1); cyc_en = 1'b0;
      if (gap > 0) cyc($urandom % gap);
    end
  endtask

  task automatic set_pin(logic v);
    ext_pin = v; cyc(4);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    cyc(3);
    chk("R1 reset cnt", cnt_rdata, 0);
    chk("R1 reset flag", ovf_flag, 0);
    chk("R1 reset ctrl", ctrl_rdata, 0);
    rst_n = 1'b1; cyc(2);

    // divide by 2 (n=0, no bypass)
    wr_ctrl(8'h00);
    strobes(5, 3);
    chk("R4 div2 five strobes", cnt_rdata, 2);
    // prescaler now holds 1; counter write must clear it
    wr_cnt(8'd10);
    chk("R5 counter load", cnt_rdata, 10);
    strobes(1, 0);
    chk("R6 prescaler cleared by counter write", cnt_rdata, 10);
    strobes(1, 0);
    chk("R6 period restarts", cnt_rdata, 11);
    // control write clears prescaler
    strobes(1, 0);
    wr_ctrl(8'h00);
    strobes(1, 0);
    chk("R7 prescaler cleared by control write", cnt_rdata, 11);
    // event in the same cycle as a control write is lost
    wr_ctrl(8'h08);
    cyc_en = 1'b1; wr_ctrl(8'h08); cyc_en = 1'b0;
    chk("R7 event during control write", cnt_rdata, 11);
    strobes(3, 2);
    chk("R4 bypass", cnt_rdata, 14);
    // write beats advance
    cyc_en = 1'b1; wr_cnt(8'd77); cyc_en = 1'b0;
    chk("R10 write over advance", cnt_rdata, 77);
    // wrap
    wr_cnt(8'hFF);
    strobes(1, 0);
    chk("R8 wrap value", cnt_rdata, 0);
    chk("R8 wrap flag", ovf_flag, 1);
    wr_flag(1'b1);
    chk("R9 write 1 ignored", ovf_flag, 1);
    wr_flag(1'b0);
    chk("R9 write 0 clears", ovf_flag, 0);
    wr_cnt(8'hFF);
    flag_wr = 1'b1; flag_wdata = 1'b0; cyc_en = 1'b1; cyc(1);
    flag_wr = 1'b0; cyc_en = 1'b0;
    chk("R9 wrap beats clear", ovf_flag, 1);
    wr_flag(1'b0);

    // external source, rising, bypass
    wr_ctrl(8'h28);
    chk("R11 ctrl readback", ctrl_rdata, 8'h28);
    wr_cnt(8'd0);
    strobes(4, 2);
    chk("R2 strobes ignored on pin source", cnt_rdata, 0);
    ext_pin = 1'b1; cyc(1); cyc(1);
    chk("R3 no count before k+2", cnt_rdata, 0);
    cyc(1);
    chk("R3 count at k+2", cnt_rdata, 1);
    set_pin(1'b0);
    chk("R3 falling ignored when rising selected", cnt_rdata, 1);
    wr_ctrl(8'h38);
    set_pin(1'b1);
    chk("R3 rising ignored when falling selected", cnt_rdata, 1);
    set_pin(1'b0);
    chk("R3 falling counted", cnt_rdata, 2);
    // pin ignored on strobe source
    wr_ctrl(8'h08);
    set_pin(1'b1); set_pin(1'b0);
    chk("R2 pin ignored on strobe source", cnt_rdata, 2);

    // watchdog reset
    wr_ctrl(8'h3D); wr_cnt(8'h5A);
    wdt_rst = 1'b1; cyc(1); wdt_rst = 1'b0;
    chk("R1 wdt cnt", cnt_rdata, 0);
    chk("R1 wdt ctrl", ctrl_rdata, 0);

    // random strobe trains
    for (int it = 0; it < 20; it++) begin
      logic [7:0] c, s;
      int n, t;
      c = {2'b00, 1'b0, 1'($urandom), 1'(($urandom % 4) == 0), 3'($urandom)};
      s = 8'($urandom);
      n = $urandom % 600;
      wr_ctrl(c); wr_cnt(s); wr_flag(1'b0);
      strobes(n, 3);
      t = total_after(s, n, c);
      chk("R4 random strobe count", cnt_rdata, t % 256);
      chk("R8 random overflow", ovf_flag, (t > 255) ? 1 : 0);
    end

    // random pin trains
    for (int it = 0; it < 12; it++) begin
      logic [7:0] c, s;
      int edges, t;
      logic fe;
      fe = 1'($urandom);
      c = {2'b00, 1'b1, fe, 1'(($urandom % 3) == 0), 3'($urandom % 3)};
      s = 8'($urandom);
      wr_ctrl(c); wr_cnt(s);
      edges = 0;
      for (int k = 0; k < 40 + int'($urandom % 40); k++) begin
        logic nv;
        nv = ~ext_pin;
        if ((nv == 1'b1 && !fe) || (nv == 1'b0 && fe)) edges++;
        set_pin(nv);
      end
      t = total_after(s, edges, c);
      chk("R3 random pin count", cnt_rdata, t % 256);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule